// File: doc/BRIEF.md
# Chip-Select Address Decoder

This block turns a 32-bit bus address into a chip select. The upper ten address bits, from bit 22 to bit 31, are compared with a select field that each chip select owns. A single base mask, shared by all chip selects, chooses which of those bits take part in the comparison. A chip select can match only while its enable bit is set. When more than one chip select matches, the lowest index is picked.

The block has no configuration storage of its own. The enable bits, the select fields and the base mask come in as parallel inputs from a register file elsewhere. Any change to them takes part in the very next decode. When the address is flagged valid, the result is registered and appears one clock later as a one-hot vector plus a hit flag. Arbitration, memory timing and error reporting are handled outside this block.

Top module: `csdec_top`

## Requirements
- R1: While `rst` is high at a rising edge, `cs_hot` and `cs_hit` are zero after that edge.
- R2: Chip select i matches when `((addr[31:22] ^ sel_i) & base_mask) == 0` and its enable bit is set. Here `sel_i` is bits `[10*i+9 : 10*i]` of `cfg_sel`.
- R3: A chip select whose bit in `cfg_en` is low is never selected, even if its select field matches.
- R4: When several chip selects match, only the lowest-indexed one is driven high in `cs_hot`. `cs_hot` never has more than one bit set.
- R5: `cs_hit` is high exactly when `cs_hot` is nonzero. When nothing matches, both are zero.
- R6: A decode is registered. The result for an address presented with `addr_vld` high appears after the next rising edge. A cycle with `addr_vld` low gives zero outputs after that edge.
- R7: A new value on `cfg_en`, `cfg_sel` or `base_mask` takes effect in the same decode as the address it is presented with. There is no extra latency.
- R8: Address bits `[21:0]` have no effect on the result.
- R9: A zero bit in `base_mask` removes that address bit from the comparison. With `base_mask` all zero, every enabled chip select matches, so the lowest enabled index wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_vld | input | 1 | Address is valid this cycle |
| addr | input | 32 | Bus address |
| cfg_en | input | NUM_CS | Per-chip-select enable bits |
| cfg_sel | input | NUM_CS*10 | Packed select fields, chip select i at bits [10*i+9:10*i] |
| base_mask | input | 10 | Shared compare mask for address bits [31:22] |
| cs_hot | output | NUM_CS | Registered one-hot chip select |
| cs_hit | output | 1 | Registered hit flag |

## Verification
The hardest case to reach is two enabled chip selects with identical select fields, because then the priority order alone decides the result. The bench sets two entries to the same field to create this overlap. It also clears the mask, so that every enabled chip select matches at once. The stimulus then disables the lowest entries one after another, to show that the winner moves upward in index order. Configuration changes are applied in the same cycle as a new address, which shows that no stale configuration affects the decode.

// File: rtl/csdec_pkg.sv
package csdec_pkg;
    localparam int ADDR_W  = 32;
    localparam int SEL_LSB = 22;
    localparam int SEL_W   = ADDR_W - SEL_LSB;

    typedef logic [SEL_W-1:0] sel_t;

    typedef struct packed {
        logic en;
        sel_t sel;
    } cs_cfg_t;

    // True when every bit kept by the mask agrees between the two fields.
    function automatic logic field_match(sel_t a, sel_t b, sel_t m);
        return ((a ^ b) & m) == '0;
    endfunction
endpackage

// File: rtl/csdec_cmp.sv
module csdec_cmp
    import csdec_pkg::*;
#(
    parameter int NUM_CS = 8
) (
    input  sel_t                  addr_hi,
    input  sel_t                  mask,
    input  cs_cfg_t [NUM_CS-1:0]  cfg,
    output logic    [NUM_CS-1:0]  match
);
    for (genvar i = 0; i < NUM_CS; i++) begin : g_cmp
        assign match[i] = cfg[i].en && field_match(addr_hi, cfg[i].sel, mask);
    end
endmodule

// File: rtl/csdec_prio.sv
module csdec_prio #(
    parameter int N = 8
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt,
    output logic         any
);
    // Isolate the lowest set bit.
    assign gnt = req & (~req + N'(1));
    assign any = |req;
endmodule

// File: rtl/csdec_top.sv
module csdec_top
    import csdec_pkg::*;
#(
    parameter int NUM_CS = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    addr_vld,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [NUM_CS-1:0]       cfg_en,
    input  logic [NUM_CS*SEL_W-1:0] cfg_sel,
    input  logic [SEL_W-1:0]        base_mask,
    output logic [NUM_CS-1:0]       cs_hot,
    output logic                    cs_hit
);
    cs_cfg_t [NUM_CS-1:0] cfg;
    logic    [NUM_CS-1:0] match;
    logic    [NUM_CS-1:0] gnt;
    logic                 any;
    sel_t                 addr_hi;
    logic                 unused_low;

    assign addr_hi    = addr[ADDR_W-1:SEL_LSB];
    assign unused_low = ^addr[SEL_LSB-1:0];

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cfg
        assign cfg[i].en  = cfg_en[i];
        assign cfg[i].sel = cfg_sel[i*SEL_W +: SEL_W];
    end

    csdec_cmp #(.NUM_CS(NUM_CS)) u_cmp (
        .addr_hi (addr_hi),
        .mask    (base_mask),
        .cfg     (cfg),
        .match   (match)
    );

    csdec_prio #(.N(NUM_CS)) u_prio (
        .req (match),
        .gnt (gnt),
        .any (any)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_hot <= '0;
            cs_hit <= 1'b0;
        end else if (addr_vld) begin
            cs_hot <= gnt;
            cs_hit <= any;
        end else begin
            cs_hot <= '0;
            cs_hit <= 1'b0;
        end
    end
endmodule

// File: rtl/csdec_chk.sv
module csdec_chk #(
    parameter int NUM_CS = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              addr_vld,
    input logic [NUM_CS-1:0] cfg_en,
    input logic [NUM_CS-1:0] cs_hot,
    input logic              cs_hit
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (cs_hot == '0 && !cs_hit));

    a_r4_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cs_hot));

    a_r5_hit_matches_vec: assert property (@(posedge clk) disable iff (rst)
        cs_hit == (cs_hot != '0));

    a_r6_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !addr_vld |=> (!cs_hit && cs_hot == '0));

    a_r3_enabled_only: assert property (@(posedge clk) disable iff (rst)
        addr_vld |=> ((cs_hot & ~$past(cfg_en)) == '0));
endmodule

bind csdec_top csdec_chk #(.NUM_CS(NUM_CS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .addr_vld (addr_vld),
    .cfg_en   (cfg_en),
    .cs_hot   (cs_hot),
    .cs_hit   (cs_hit)
);

// File: tb/sim_csdec_top.sv
module sim_csdec_top;
    localparam int N  = 8;
    localparam int SW = 10;

    typedef struct {
        logic [N-1:0] cs;
        logic         hit;
        string        tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              addr_vld = 1'b0;
    logic [31:0]       addr = '0;
    logic [N-1:0]      en = '0;
    logic [SW-1:0]     sel [N];
    logic [N*SW-1:0]   sel_flat;
    logic [SW-1:0]     mask = '1;
    logic [N-1:0]      cs_hot;
    logic              cs_hit;

    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;
    exp_t q[$];

    always #10 clk = ~clk;

    always_comb
        for (int i = 0; i < N; i++) sel_flat[i*SW +: SW] = sel[i];

    csdec_top #(.NUM_CS(N)) u0 (
        .clk(clk), .rst(rst), .addr_vld(addr_vld), .addr(addr),
        .cfg_en(en), .cfg_sel(sel_flat), .base_mask(mask),
        .cs_hot(cs_hot), .cs_hit(cs_hit)
    );

    function automatic exp_t model(logic v, logic [31:0] a, string tag);
        exp_t e;
        e.cs = '0; e.hit = 1'b0; e.tag = tag;
        if (v)
            for (int i = 0; i < N; i++)
                if (!e.hit && en[i] && (((a[31:22] ^ sel[i]) & mask) == '0)) begin
                    e.cs[i] = 1'b1;
                    e.hit   = 1'b1;
                end
        return e;
    endfunction

    task automatic go(input logic v, input logic [31:0] a, input string tag);
        @(negedge clk);
        addr_vld = v;
        addr     = a;
        q.push_back(model(v, a, tag));
        @(posedge clk);
        #1;
    endtask

    // Monitor: compare registered outputs right after each capturing edge.
    initial forever begin
        @(posedge clk);
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (cs_hot !== e.cs || cs_hit !== e.hit) begin
                errors++;
                $display("FAIL %s: got cs=%b hit=%b, expected cs=%b hit=%b",
                         e.tag, cs_hot, cs_hit, e.cs, e.hit);
            end
        end
    end

    initial begin
        #(20 * 50000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) sel[i] = SW'(i * 3 + 1);
        en = '1;
        repeat (3) @(posedge clk);
        #2;
        checks++;  // R1: reset clears outputs
        if (cs_hot !== '0 || cs_hit !== 1'b0) begin
            errors++;
            $display("FAIL R1: got cs=%b hit=%b, expected cs=0 hit=0", cs_hot, cs_hit);
        end
        @(negedge clk);
        rst = 1'b0;

        // R2: exact match on every chip select, back to back (R6 latency)
        for (int i = 0; i < N; i++)
            go(1'b1, {sel[i], 22'h0}, "R2/R6 sweep");
        // R8: low address bits ignored
        go(1'b1, {sel[5], 22'h3FFFFF}, "R8 low bits ones");
        go(1'b1, {sel[5], 22'h155555}, "R8 low bits pattern");
        // R5: no match
        go(1'b1, {10'h3FF, 22'h0}, "R5 no match");
        // R6: valid low gives zero
        go(1'b0, {sel[2], 22'h0}, "R6 valid low");
        // R3: disabled chip select ignored
        en[5] = 1'b0;
        go(1'b1, {sel[5], 22'h0}, "R3 disabled");
        en[5] = 1'b1;
        // R4: overlapping fields, lowest index wins
        sel[6] = sel[2];
        go(1'b1, {sel[2], 22'h0}, "R4 overlap 2/6");
        en[2] = 1'b0;
        go(1'b1, {sel[2], 22'h0}, "R4 overlap with 2 off");
        en[2] = 1'b1;
        // R9: zero mask, every enabled chip select matches
        mask = '0;
        go(1'b1, 32'hDEAD_BEEF, "R9 mask zero");
        en[0] = 1'b0;
        go(1'b1, 32'h1234_5678, "R9 mask zero cs0 off");
        en[1] = 1'b0;
        go(1'b1, 32'h0, "R9 mask zero cs0,1 off");
        en = '1;
        // R9: partial mask ignores low select bits
        mask = 10'h3F0;
        go(1'b1, {sel[7] ^ 10'h00F, 22'h0}, "R9 partial mask");
        mask = '1;
        go(1'b1, {sel[7] ^ 10'h00F, 22'h0}, "R2 full mask miss");
        // R7: config change applies at once
        sel[3] = 10'h2AA;
        go(1'b1, {10'h2AA, 22'h0}, "R7 new sel");
        sel[3] = 10'h155;
        go(1'b1, {10'h2AA, 22'h0}, "R7 sel moved away");
        mask = 10'h200;
        go(1'b1, {10'h2AA, 22'h0}, "R7 new mask");
        mask = '1;

        repeat (3) @(posedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule